// File: doc/BRIEF.md
# Wear-Leveling Record Logger

This block saves one data word at a time into a byte-wide non-volatile memory. It spreads the saves over a ring of slots so that no single cell takes every write. Each slot holds the data word and a sequence number of its own, so no shared counter location exists to wear out. After every reset the block reads all slots and picks the newest valid record. The next save goes to the slot after that one.

A host raises `req_i` with a word on `data_i` while `ready_o` is high. The block first reads the data bytes of the current record. If the word is unchanged, it stops without writing. Otherwise it writes data and sequence into the next slot, reads the whole slot back and compares it. It then pulses `done_o`, with `skip_o` and `err_o` qualifying the result. Every memory access is a request held until the memory signals completion, so the block needs no assumption about program time.

Top module: `wl_record_logger`

## Requirements
- R1: Each committed save goes to slot (previous slot + 1) mod N_SLOTS. Slot k occupies bytes BASE_ADDR + k*REC_B upward. The data bytes come first, least significant byte first, and the sequence bytes follow.
- R2: The sequence of a committed save is the previous sequence + 1 mod 2^SEQ_W. The all-ones value is skipped, so the sequence after 8'hFE is 8'h00. `rec_valid_o` never shows an all-ones sequence.
- R3: After reset the block scans every slot before raising `ready_o`. Sequence a is newer than b when (a-b) mod 2^SEQ_W lies in 1..2^(SEQ_W-1)-1. The newest valid slot appears on `rec_slot_o`, `rec_seq_o` and `rec_data_o`, and the next save uses the slot after it.
- R4: A slot whose sequence field is all ones is empty. If every slot is empty, `rec_valid_o` is 0 and the first save goes to slot 0 with sequence 0, using no compare read.
- R5: A save whose word equals the current record's stored data writes nothing. It pulses `done_o` with `skip_o`=1 and leaves the record outputs unchanged.
- R6: After writing, every byte of the slot is read back. Any mismatch gives `done_o` with `err_o`=1, and the record outputs keep their previous values.
- R7: Each access holds `mem_req_o`, `mem_addr_o` and `mem_we_o` until `mem_done_i`. A save with a valid record makes exactly DB + 2*REC_B accesses, or DB if skipped. A save with no valid record makes 2*REC_B accesses.
- R8: No access goes below BASE_ADDR (nonzero) or above the last byte of the ring.
- R9: `ready_o` is high only when idle. `req_i` while `ready_o` is low is ignored.
- R10: Each accepted request yields exactly one single-cycle `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Save request, sampled when ready_o is high |
| data_i | input | DATA_W | Word to save |
| ready_o | output | 1 | Idle, accepting a request |
| done_o | output | 1 | One-cycle end-of-save pulse |
| skip_o | output | 1 | With done_o: write skipped, value unchanged |
| err_o | output | 1 | With done_o: read-back mismatch |
| rec_valid_o | output | 1 | A valid record exists |
| rec_slot_o | output | SLOT_W | Slot of the newest record |
| rec_seq_o | output | SEQ_W | Sequence of the newest record |
| rec_data_o | output | DATA_W | Data of the newest record |
| mem_req_o | output | 1 | Memory access request, held until done |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_done_i | input | 1 | Access complete (one cycle) |
| mem_rdata_i | input | 8 | Read byte, valid with mem_done_i |

## Verification
The latency of a save depends on the memory's random completion delay. The bench therefore never counts cycles to a result: it waits for the `done_o` pulse at a falling edge. The scoreboard pops the expected skip and error flags in that same cycle. The record outputs and the bench's memory image are checked one falling edge later, after the block has returned to idle. The scan result is checked once `ready_o` first rises after reset, because the scan's duration also depends on the memory.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [2:0] {
    ST_SCAN, ST_EVAL, ST_IDLE, ST_CMP, ST_WR, ST_VF, ST_FIN
  } wl_state_e;
endpackage

// File: rtl/wl_seq_newer.sv
module wl_seq_newer #(
  parameter int SEQ_W = 8
) (
  input  logic [SEQ_W-1:0] a_i,
  input  logic [SEQ_W-1:0] b_i,
  output logic             newer_o
);
  logic [SEQ_W-1:0] diff;
  // wrap-aware: a is ahead of b by less than half the sequence space
  always_comb begin
    diff    = a_i - b_i;
    newer_o = (diff != '0) && !diff[SEQ_W-1];
  end
endmodule

// File: rtl/wl_byte_port.sv
module wl_byte_port #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              idle_o,
  output logic              done_o,
  output logic [7:0]        rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_done_i,
  input  logic [7:0]        mem_rdata_i
);
  logic              req_q, we_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !req_q) begin
        req_q   <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end else if (req_q && mem_done_i) begin
        req_q   <= 1'b0;
        done_q  <= 1'b1;
        rdata_q <= mem_rdata_i;
      end
    end
  end

  assign idle_o      = !req_q && !done_q;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_done_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  p_done_after_mem_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_done_i |=> done_o && !mem_req_o);
endmodule

// File: rtl/wl_record_logger.sv
module wl_record_logger
  import wl_pkg::*;
#(
  parameter int N_SLOTS   = 4,
  parameter int DATA_W    = 16,
  parameter int SEQ_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 16,
  localparam int SLOT_W   = $clog2(N_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              skip_o,
  output logic              err_o,
  output logic              rec_valid_o,
  output logic [SLOT_W-1:0] rec_slot_o,
  output logic [SEQ_W-1:0]  rec_seq_o,
  output logic [DATA_W-1:0] rec_data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_done_i,
  input  logic [7:0]        mem_rdata_i
);
  localparam int DB     = DATA_W / 8;
  localparam int SB     = SEQ_W / 8;
  localparam int REC_B  = DB + SB;
  localparam int REC_W  = REC_B * 8;
  localparam int BYTE_W = $clog2(REC_B);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE_ADDR + N_SLOTS * REC_B - 1);
  localparam logic [SEQ_W-1:0]  EMPTY  = '1;
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(N_SLOTS - 1);

  wl_state_e         state_q;
  logic [SLOT_W-1:0] scan_slot_q, cur_slot_q, tgt_slot_q;
  logic [BYTE_W-1:0] byte_q;
  logic [REC_W-1:0]  buf_q;
  logic              cur_valid_q;
  logic [SEQ_W-1:0]  cur_seq_q, tgt_seq_q;
  logic [DATA_W-1:0] cur_data_q, new_data_q;
  logic              diff_q, skip_q, err_q;

  logic              acc_st, bp_start, bp_idle, bp_done;
  logic              bp_we;
  logic [7:0]        bp_rdata, exp_byte;
  logic [SLOT_W-1:0] acc_slot, nxt_slot;
  logic [ADDR_W-1:0] acc_addr;
  logic [REC_W-1:0]  wrec;
  logic [SEQ_W-1:0]  buf_seq, inc_seq;
  logic [DATA_W-1:0] buf_data;
  logic              last_rec, last_dat, byte_mis, scan_newer;

  always_comb begin
    acc_st   = (state_q == ST_SCAN) || (state_q == ST_CMP) ||
               (state_q == ST_WR)   || (state_q == ST_VF);
    bp_start = acc_st && bp_idle;
    bp_we    = (state_q == ST_WR);
    acc_slot = (state_q == ST_SCAN) ? scan_slot_q :
               (state_q == ST_CMP)  ? cur_slot_q  : tgt_slot_q;
    acc_addr = BASE_A + ADDR_W'(int'(acc_slot) * REC_B) + ADDR_W'(byte_q);
    wrec     = {tgt_seq_q, new_data_q};
    exp_byte = wrec[int'(byte_q)*8 +: 8];
    last_rec = (byte_q == BYTE_W'(REC_B - 1));
    last_dat = (byte_q == BYTE_W'(DB - 1));
    byte_mis = (bp_rdata != exp_byte);
    buf_seq  = buf_q[REC_W-1 -: SEQ_W];
    buf_data = buf_q[DATA_W-1:0];
    nxt_slot = (cur_slot_q == SLOT_MAX) ? '0 : cur_slot_q + 1'b1;
    inc_seq  = cur_seq_q + 1'b1;
    if (inc_seq == EMPTY) inc_seq = '0;
  end

  wl_seq_newer #(.SEQ_W(SEQ_W)) u_newer (
    .a_i     (buf_seq),
    .b_i     (cur_seq_q),
    .newer_o (scan_newer)
  );

  wl_byte_port #(.ADDR_W(ADDR_W)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (bp_start),
    .we_i        (bp_we),
    .addr_i      (acc_addr),
    .wdata_i     (exp_byte),
    .idle_o      (bp_idle),
    .done_o      (bp_done),
    .rdata_o     (bp_rdata),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_done_i  (mem_done_i),
    .mem_rdata_i (mem_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_SCAN;
      scan_slot_q <= '0;
      cur_slot_q  <= '0;
      tgt_slot_q  <= '0;
      byte_q      <= '0;
      buf_q       <= '0;
      cur_valid_q <= 1'b0;
      cur_seq_q   <= '0;
      tgt_seq_q   <= '0;
      cur_data_q  <= '0;
      new_data_q  <= '0;
      diff_q      <= 1'b0;
      skip_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SCAN: if (bp_done) begin
          buf_q[int'(byte_q)*8 +: 8] <= bp_rdata;
          if (last_rec) begin
            byte_q  <= '0;
            state_q <= ST_EVAL;
          end else byte_q <= byte_q + 1'b1;
        end
        ST_EVAL: begin
          if (buf_seq != EMPTY && (!cur_valid_q || scan_newer)) begin
            cur_valid_q <= 1'b1;
            cur_slot_q  <= scan_slot_q;
            cur_seq_q   <= buf_seq;
            cur_data_q  <= buf_data;
          end
          if (scan_slot_q == SLOT_MAX) state_q <= ST_IDLE;
          else begin
            scan_slot_q <= scan_slot_q + 1'b1;
            state_q     <= ST_SCAN;
          end
        end
        ST_IDLE: if (req_i) begin
          new_data_q <= data_i;
          byte_q     <= '0;
          diff_q     <= 1'b0;
          skip_q     <= 1'b0;
          err_q      <= 1'b0;
          if (cur_valid_q) begin
            tgt_slot_q <= nxt_slot;
            tgt_seq_q  <= inc_seq;
            state_q    <= ST_CMP;
          end else begin
            tgt_slot_q <= '0;
            tgt_seq_q  <= '0;
            state_q    <= ST_WR;
          end
        end
        ST_CMP: if (bp_done) begin
          if (last_dat) begin
            byte_q <= '0;
            diff_q <= 1'b0;
            if (!diff_q && !byte_mis) begin
              skip_q  <= 1'b1;
              state_q <= ST_FIN;
            end else state_q <= ST_WR;
          end else begin
            byte_q <= byte_q + 1'b1;
            diff_q <= diff_q | byte_mis;
          end
        end
        ST_WR: if (bp_done) begin
          if (last_rec) begin
            byte_q  <= '0;
            diff_q  <= 1'b0;
            state_q <= ST_VF;
          end else byte_q <= byte_q + 1'b1;
        end
        ST_VF: if (bp_done) begin
          if (last_rec) begin
            if (diff_q || byte_mis) err_q <= 1'b1;
            else begin
              cur_valid_q <= 1'b1;
              cur_slot_q  <= tgt_slot_q;
              cur_seq_q   <= tgt_seq_q;
              cur_data_q  <= new_data_q;
            end
            state_q <= ST_FIN;
          end else begin
            byte_q <= byte_q + 1'b1;
            diff_q <= diff_q | byte_mis;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign skip_o      = skip_q;
  assign err_o       = err_q;
  assign rec_valid_o = cur_valid_q;
  assign rec_slot_o  = cur_slot_q;
  assign rec_seq_o   = cur_seq_q;
  assign rec_data_o  = cur_data_q;

  initial begin
    a_base_nonzero_r8: assert (BASE_ADDR > 0);
    a_byte_multiple_r1: assert ((DATA_W % 8 == 0) && (SEQ_W % 8 == 0));
  end

  p_addr_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o >= BASE_A) && (mem_addr_o <= LAST_A));
  p_ready_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_seq_not_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> rec_seq_o != EMPTY);
  p_skip_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && skip_o |-> $stable(rec_seq_o) && $stable(rec_slot_o) && !err_o);
  p_err_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> $stable(rec_seq_o) && $stable(rec_slot_o));
  p_advance_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !skip_o && !err_o && $past(rec_valid_o) |->
      rec_slot_o == (($past(rec_slot_o) == SLOT_MAX) ? '0 : $past(rec_slot_o) + 1'b1));
endmodule

// File: tb/wl_record_logger_test.sv
`timescale 1ns/1ps
module wl_record_logger_test;
  localparam int N = 4, DW = 16, SW = 8, AW = 8, BASE = 16, RB = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          ready_o, done_o, skip_o, err_o, rec_valid_o;
  logic [1:0]    rec_slot_o;
  logic [SW-1:0] rec_seq_o;
  logic [DW-1:0] rec_data_o;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_done = 1'b0;
  logic [7:0]    mem_rdata = '0;

  wl_record_logger #(.N_SLOTS(N), .DATA_W(DW), .SEQ_W(SW), .ADDR_W(AW), .BASE_ADDR(BASE)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .data_i(data_i),
    .ready_o(ready_o), .done_o(done_o), .skip_o(skip_o), .err_o(err_o),
    .rec_valid_o(rec_valid_o), .rec_slot_o(rec_slot_o), .rec_seq_o(rec_seq_o),
    .rec_data_o(rec_data_o), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_done_i(mem_done),
    .mem_rdata_i(mem_rdata));

  // behavioural memory: random completion delay, optional bit flip on one write
  logic [7:0] mem [256];
  int  lat = 2, acc_cnt = 0, wr_cnt = 0;
  bit  low_hit = 0, inject = 0;

  always @(posedge clk) begin
    mem_done <= 1'b0;
    if (mem_req && !mem_done) begin
      if (lat == 0) begin
        acc_cnt = acc_cnt + 1;
        if (mem_addr < AW'(BASE)) low_hit = 1;
        if (mem_we) begin
          wr_cnt = wr_cnt + 1;
          mem[mem_addr] = inject ? (mem_wdata ^ 8'h01) : mem_wdata;
          inject = 0;
        end else mem_rdata <= mem[mem_addr];
        mem_done <= 1'b1;
        lat = int'($urandom % 4);
      end else lat = lat - 1;
    end
  end

  int n_chk = 0, n_fail = 0, done_cnt = 0;
  typedef struct { bit skip; bit err; } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && done_o) begin
      done_cnt++;
      if (q.size() == 0) chk(1'b0, "R10 done without request", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(skip_o == e.skip, "R5 skip flag", int'(skip_o), int'(e.skip));
        chk(err_o == e.err, "R6 error flag", int'(err_o), int'(e.err));
      end
    end
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    do @(negedge clk); while (!ready_o);
  endtask

  task automatic save(input logic [DW-1:0] d, input bit es, input bit ee);
    exp_t e;
    e.skip = es; e.err = ee;
    while (!ready_o) @(negedge clk);
    q.push_back(e);
    req_i = 1'b1; data_i = d;
    @(negedge clk);
    req_i = 1'b0;
    do @(negedge clk); while (!done_o);
    @(negedge clk);
  endtask

  task automatic chk_slot(input int k, input logic [DW-1:0] d, input logic [SW-1:0] s, input string tag);
    int a;
    a = BASE + k * RB;
    chk({mem[a+1], mem[a]} == d, {tag, " slot data"}, int'({mem[a+1], mem[a]}), int'(d));
    chk(mem[a+2] == s, {tag, " slot seq"}, int'(mem[a+2]), int'(s));
  endtask

  task automatic chk_rec(input int k, input logic [SW-1:0] s, input logic [DW-1:0] d, input string tag);
    chk(rec_valid_o == 1'b1, {tag, " valid"}, int'(rec_valid_o), 1);
    chk(int'(rec_slot_o) == k, {tag, " slot"}, int'(rec_slot_o), k);
    chk(rec_seq_o == s, {tag, " seq"}, int'(rec_seq_o), int'(s));
    chk(rec_data_o == d, {tag, " data"}, int'(rec_data_o), int'(d));
  endtask

  task automatic preload(input int k, input logic [DW-1:0] d, input logic [SW-1:0] s);
    mem[BASE + k*RB]     = d[7:0];
    mem[BASE + k*RB + 1] = d[15:8];
    mem[BASE + k*RB + 2] = s;
  endtask

  task automatic erase();
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int a0, w0;
    erase();
    do_reset();
    // R4: blank memory, no record
    chk(rec_valid_o == 1'b0, "R4 empty scan valid", int'(rec_valid_o), 0);
    chk(ready_o == 1'b1, "R9 ready when idle", int'(ready_o), 1);

    a0 = acc_cnt;
    save(16'h1234, 0, 0);
    chk(acc_cnt - a0 == 2*RB, "R7 R4 access count first save", acc_cnt - a0, 2*RB);
    chk_slot(0, 16'h1234, 8'h00, "R4 R2 first save");
    chk_rec(0, 8'h00, 16'h1234, "R4 first record");

    // R5: same value skipped
    a0 = acc_cnt; w0 = wr_cnt;
    save(16'h1234, 1, 0);
    chk(wr_cnt == w0, "R5 no write on equal value", wr_cnt - w0, 0);
    chk(acc_cnt - a0 == 2, "R7 R5 skip access count", acc_cnt - a0, 2);
    chk_rec(0, 8'h00, 16'h1234, "R5 record unchanged");

    // R1 R2: rotation through the ring
    for (int i = 1; i <= 5; i++) begin
      a0 = acc_cnt;
      save(16'hA000 + 16'(i), 0, 0);
      if (i == 1) chk(acc_cnt - a0 == 2 + 2*RB, "R7 access count", acc_cnt - a0, 2 + 2*RB);
      chk_rec(i % N, SW'(i), 16'hA000 + 16'(i), "R1 R2 rotation");
      chk_slot(i % N, 16'hA000 + 16'(i), SW'(i), "R1 memory layout");
    end
    chk(low_hit == 0, "R8 no access below base", int'(low_hit), 0);

    // R3: rescan after reset finds newest
    do_reset();
    chk_rec(1, 8'h05, 16'hA005, "R3 rescan");
    save(16'hB000, 0, 0);
    chk_rec(2, 8'h06, 16'hB000, "R3 resume next slot");
    chk_slot(2, 16'hB000, 8'h06, "R3 resume memory");

    // R3: wrap-aware ordering
    erase();
    preload(0, 16'h1111, 8'h01);
    preload(1, 16'h2222, 8'hFD);
    preload(2, 16'h3333, 8'hFE);
    preload(3, 16'h4444, 8'h00);
    do_reset();
    chk_rec(0, 8'h01, 16'h1111, "R3 wrap scan");
    save(16'h5555, 0, 0);
    chk_rec(1, 8'h02, 16'h5555, "R3 wrap resume");

    // R2: all-ones sequence skipped on increment
    erase();
    preload(2, 16'h7777, 8'hFE);
    do_reset();
    chk_rec(2, 8'hFE, 16'h7777, "R4 single valid slot");
    save(16'h8888, 0, 0);
    chk_rec(3, 8'h00, 16'h8888, "R2 seq skips ones");
    chk_slot(3, 16'h8888, 8'h00, "R2 seq skip memory");

    // R6: corrupted write caught by read-back
    inject = 1;
    save(16'h9999, 0, 1);
    chk_rec(3, 8'h00, 16'h8888, "R6 record held on error");
    save(16'h9999, 0, 0);
    chk_rec(0, 8'h01, 16'h9999, "R6 retry same slot");

    // R9: request while busy is ignored
    begin
      exp_t e;
      e.skip = 0; e.err = 0;
      while (!ready_o) @(negedge clk);
      q.push_back(e);
      req_i = 1'b1; data_i = 16'hABCD;
      @(negedge clk);
      req_i = 1'b0;
      repeat (3) @(negedge clk);
      chk(ready_o == 1'b0, "R9 not ready while busy", int'(ready_o), 0);
      req_i = 1'b1; data_i = 16'h0123;
      @(negedge clk);
      req_i = 1'b0;
      do @(negedge clk); while (!done_o);
      repeat (20) @(negedge clk);
    end
    chk_rec(1, 8'h02, 16'hABCD, "R9 busy request ignored");
    chk(q.size() == 0, "R10 one done per request", q.size(), 0);
    chk(low_hit == 0, "R8 no access below base at end", int'(low_hit), 0);
    finish_run();
  end
endmodule